// File: doc/BRIEF.md
# Masked Receive Address Filter

This block decides, for every network address presented with a valid strobe, whether the receiver should accept the frame and acknowledge it. It compares the incoming address with the station's own address, but only on the bit positions that a programmable mask enables. A masked-out position may hold any value. Several virtual network identifiers that agree with the station address on every enabled bit are therefore all accepted by one comparator.

Software works out the mask and then writes it. For each address it keeps, software clears every bit where that address differs from the station address. The result is the set of bit positions that all handled addresses share. The filter is loose on purpose: a foreign address that happens to share those bits is accepted too.

Software writes the station address and the mask through a small word-wide register port. Each value is split into a full low word and a narrow upper field. The register that holds the upper station field also holds unrelated control bits, and a write to the address field must leave those bits unchanged.

Top module: `rx_addr_filter`

## Requirements
- R1: One cycle after a cycle with `frm_valid` high, `out_vld` is high. In that same cycle `out_accept` is high exactly when (`frm_addr` AND mask) equals (station address AND mask), using the values sampled with the strobe.
- R2: One cycle after a cycle with `frm_valid` low, both `out_vld` and `out_accept` are low.
- R3: After reset, the mask reads back as all ones, the station address as all zeros and the control bits as zeros.
- R4: Select 0 holds address bits WORD_W-1:0, and bit i of the word is address bit i. With the default widths, byte 0 of the address is in bits 7:0. Select 1 holds the upper address bits in data bits HI_W-1:0, and address byte 4 is in bits 7:0 of that field.
- R5: A write to select 1 changes only data bits HI_W-1:0. Data bits WORD_W-1:HI_W read back the control field unchanged. That field is written only through select 4, from the same data bits.
- R6: Select 2 holds mask bits WORD_W-1:0. Select 3 holds the upper mask bits in data bits HI_W-1:0, and the other bits of select 3 read as zero.
- R7: With an all-ones mask, an address is accepted only when it equals the station address on every bit.
- R8: Using address bits 3:0, with station address 0001 and mask 0010: the addresses 0001, 0100, 1001 and 1101 are accepted, and 0110 is rejected.
- R9: `rd_data` follows `rd_sel` with no clock delay. Selects 5 to 7 read as zero, and writes to them change nothing.
- R10: Without `wr_en`, the station address and the mask do not change.

Select codes: 0 station low word, 1 station upper field plus control bits, 2 mask low word, 3 mask upper field, 4 control bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset. Release is synchronised inside the block. |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for writes |
| wr_data | input | WORD_W | Write data |
| rd_sel | input | 3 | Register select for reads |
| rd_data | output | WORD_W | Read data, combinational |
| frm_valid | input | 1 | Address valid strobe |
| frm_addr | input | ADDR_W | Incoming address, byte 0 in bits 7:0 |
| out_vld | output | 1 | Decision valid, one cycle after the strobe |
| out_accept | output | 1 | Accept decision |

## Verification
The assertions assume that `frm_addr`, the register inputs and the strobes settle well away from the rising edge. They also assume the address is held stable while `frm_valid` is high. The bench drives every input on the falling edge, so each strobe samples one settled value. The bench uses a small configuration: a 6-bit address and a 4-bit word. It sweeps every mask against every address for several station addresses, and it changes the registers only between decisions, never while a strobe is in flight.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  typedef enum logic [2:0] {
    SEL_MAC_LO  = 3'd0,
    SEL_MAC_HI  = 3'd1,
    SEL_MASK_LO = 3'd2,
    SEL_MASK_HI = 3'd3,
    SEL_CTRL    = 3'd4
  } rxf_sel_e;
endpackage

// File: rtl/rxf_regs.sv
module rxf_regs
  import rxf_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [2:0]        rd_sel,
  output logic [WORD_W-1:0] rd_data,
  output logic [ADDR_W-1:0] own_mac,
  output logic [ADDR_W-1:0] mask
);
  localparam int HI_W   = ADDR_W - WORD_W;
  localparam int CTRL_W = WORD_W - HI_W;

  logic [WORD_W-1:0] mac_lo_q, mac_lo_d, msk_lo_q, msk_lo_d;
  logic [HI_W-1:0]   mac_hi_q, mac_hi_d, msk_hi_q, msk_hi_d;
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;

  // next state
  always_comb begin
    mac_lo_d = mac_lo_q;
    mac_hi_d = mac_hi_q;
    msk_lo_d = msk_lo_q;
    msk_hi_d = msk_hi_q;
    ctrl_d   = ctrl_q;
    if (wr_en) begin
      case (rxf_sel_e'(wr_sel))
        SEL_MAC_LO:  mac_lo_d = wr_data;
        SEL_MAC_HI:  mac_hi_d = wr_data[HI_W-1:0];
        SEL_MASK_LO: msk_lo_d = wr_data;
        SEL_MASK_HI: msk_hi_d = wr_data[HI_W-1:0];
        SEL_CTRL:    ctrl_d   = wr_data[WORD_W-1:HI_W];
        default:     ;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mac_lo_q <= '0;
      mac_hi_q <= '0;
      msk_lo_q <= '1;
      msk_hi_q <= '1;
      ctrl_q   <= '0;
    end else begin
      mac_lo_q <= mac_lo_d;
      mac_hi_q <= mac_hi_d;
      msk_lo_q <= msk_lo_d;
      msk_hi_q <= msk_hi_d;
      ctrl_q   <= ctrl_d;
    end
  end

  // read mux
  always_comb begin
    rd_data = '0;
    case (rxf_sel_e'(rd_sel))
      SEL_MAC_LO:  rd_data = mac_lo_q;
      SEL_MAC_HI:  rd_data = {ctrl_q, mac_hi_q};
      SEL_MASK_LO: rd_data = msk_lo_q;
      SEL_MASK_HI: rd_data = {{CTRL_W{1'b0}}, msk_hi_q};
      SEL_CTRL:    rd_data = {ctrl_q, {HI_W{1'b0}}};
      default:     rd_data = '0;
    endcase
  end

  assign own_mac = {mac_hi_q, mac_lo_q};
  assign mask    = {msk_hi_q, msk_lo_q};
endmodule

// File: rtl/rxf_match.sv
module rxf_match #(
  parameter int ADDR_W = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frm_valid,
  input  logic [ADDR_W-1:0] frm_addr,
  input  logic [ADDR_W-1:0] own_mac,
  input  logic [ADDR_W-1:0] mask,
  output logic              out_vld,
  output logic              out_accept
);
  logic hit;
  logic vld_d, acc_d, vld_q, acc_q;

  // Differences are counted only on enabled positions.
  always_comb begin
    hit   = ((frm_addr ^ own_mac) & mask) == '0;
    vld_d = frm_valid;
    acc_d = frm_valid ? hit : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      acc_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      acc_q <= acc_d;
    end
  end

  assign out_vld    = vld_q;
  assign out_accept = acc_q;
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter #(
  parameter int ADDR_W = 48,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [2:0]        rd_sel,
  output logic [WORD_W-1:0] rd_data,
  input  logic              frm_valid,
  input  logic [ADDR_W-1:0] frm_addr,
  output logic              out_vld,
  output logic              out_accept
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [ADDR_W-1:0] own_mac, mask;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  rxf_regs #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .own_mac(own_mac), .mask(mask)
  );

  rxf_match #(.ADDR_W(ADDR_W)) u_match (
    .clk(clk), .rst_n(rst_int_n), .frm_valid(frm_valid), .frm_addr(frm_addr),
    .own_mac(own_mac), .mask(mask), .out_vld(out_vld), .out_accept(out_accept)
  );
endmodule

// File: rtl/rxf_checks.sv
module rxf_checks #(
  parameter int ADDR_W = 48
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              frm_valid,
  input logic [ADDR_W-1:0] frm_addr,
  input logic [ADDR_W-1:0] own_mac,
  input logic [ADDR_W-1:0] mask,
  input logic              out_vld,
  input logic              out_accept
);
  p_accept_match_r1: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |=> (out_vld && (out_accept ==
      (($past(frm_addr) & $past(mask)) == ($past(own_mac) & $past(mask))))));

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_valid |=> (!out_vld && !out_accept));

  p_full_mask_exact_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && (&mask)) |=> (out_accept == ($past(frm_addr) == $past(own_mac))));

  p_hold_without_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(own_mac) && $stable(mask)));
endmodule

bind rx_addr_filter rxf_checks #(.ADDR_W(ADDR_W)) u_checks (
  .clk(clk), .rst_n(rst_int_n), .wr_en(wr_en), .frm_valid(frm_valid),
  .frm_addr(frm_addr), .own_mac(own_mac), .mask(mask),
  .out_vld(out_vld), .out_accept(out_accept)
);

// File: tb/rx_addr_filter_bench.sv
`timescale 1ns/1ps
module rx_addr_filter_bench;
  localparam int AW = 6;
  localparam int WW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [2:0]    wr_sel = '0;
  logic [WW-1:0] wr_data = '0;
  logic [2:0]    rd_sel = '0;
  logic [WW-1:0] rd_data;
  logic          frm_valid = 1'b0;
  logic [AW-1:0] frm_addr = '0;
  logic          out_vld, out_accept;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  rx_addr_filter #(.ADDR_W(AW), .WORD_W(WW)) u_rx_addr_filter (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .frm_valid(frm_valid), .frm_addr(frm_addr),
    .out_vld(out_vld), .out_accept(out_accept)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [WW-1:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [2:0] s, input int exp);
    @(negedge clk); rd_sel = s; #1;
    chk(tag, int'(rd_data), exp);
  endtask

  task automatic setmac(input logic [AW-1:0] m);
    wr(3'd0, m[WW-1:0]);
    wr(3'd1, {2'b00, m[AW-1:WW]});
  endtask

  task automatic setmask(input logic [AW-1:0] m);
    wr(3'd2, m[WW-1:0]);
    wr(3'd3, {2'b00, m[AW-1:WW]});
  endtask

  task automatic frame(input string tag, input logic [AW-1:0] f, input bit exp);
    @(negedge clk); frm_valid = 1'b1; frm_addr = f;
    @(posedge clk); #1;
    chk({tag, " vld"}, int'(out_vld), 1);
    chk({tag, " acc"}, int'(out_accept), int'(exp));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] macs [4];
    macs[0] = 6'h00; macs[1] = 6'h2A; macs[2] = 6'h15; macs[3] = 6'h3F;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R3 reset values
    rd("R3 mask lo", 3'd2, 4'hF);
    rd("R3 mask hi", 3'd3, 4'h3);
    rd("R3 mac lo", 3'd0, 0);
    rd("R3 mac hi", 3'd1, 0);
    // R2 idle outputs
    chk("R2 idle vld", int'(out_vld), 0);

    // R4 / R5 / R6 / R9 register layout
    setmac(6'h2D);
    rd("R4 mac lo", 3'd0, 4'hD);
    rd("R4 mac hi", 3'd1, 4'h2);
    wr(3'd4, 4'b1000);
    rd("R5 ctrl via hi", 3'd1, 4'b1010);
    wr(3'd1, 4'b0111);
    rd("R5 hi write keeps ctrl", 3'd1, 4'b1011);
    rd("R5 ctrl reg", 3'd4, 4'b1000);
    setmask(6'h1C);
    rd("R6 mask lo", 3'd2, 4'hC);
    rd("R6 mask hi", 3'd3, 4'h1);
    wr(3'd5, 4'hF);
    rd("R9 unused sel", 3'd5, 0);
    rd("R9 mac lo after unused write", 3'd0, 4'hD);

    // R8 four-bit example
    setmac(6'h01);
    setmask(6'h02);
    frame("R8 0001", 6'h01, 1'b1);
    frame("R8 0100", 6'h04, 1'b1);
    frame("R8 1001", 6'h09, 1'b1);
    frame("R8 1101", 6'h0D, 1'b1);
    frame("R8 0110", 6'h06, 1'b0);
    @(negedge clk); frm_valid = 1'b0;
    @(posedge clk); #1;
    chk("R2 vld after idle", int'(out_vld), 0);
    chk("R2 acc after idle", int'(out_accept), 0);

    // R1 / R7 exhaustive sweep
    for (int mi = 0; mi < 4; mi++) begin
      setmac(macs[mi]);
      for (int mk = 0; mk < 64; mk++) begin
        @(negedge clk); frm_valid = 1'b0;
        setmask(AW'(mk));
        for (int f = 0; f < 64; f++) begin
          frame(mk == 63 ? "R7 exact" : "R1 masked", AW'(f),
                ((f & mk) == (int'(macs[mi]) & mk)));
        end
      end
    end
    @(negedge clk); frm_valid = 1'b0;
    // R10 values held with no writes
    rd("R10 mask hold", 3'd3, 4'h3);
    rd("R10 mac hold", 3'd0, 4'hF);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule